// File: doc/BRIEF.md
# SHA-1 Message Schedule with Ring-Buffer Delay Store

This block feeds a SHA-1 compression datapath with one 32-bit schedule word per round for all 80 rounds of a 512-bit block. The first sixteen words are the block's own words, taken one per accepted input beat. The remaining sixty-four are generated internally. Each generated word is the exclusive-OR of the words three, eight, fourteen and sixteen rounds back, rotated left by one bit.

The past words are not kept in a sixteen-stage shift chain. They sit in two small chained ring memories of eight live entries each. Each memory has synchronous write and asynchronous read. Every accepted or generated word enters the first ring. The word it displaces (eight rounds old) moves into the second ring. All read addresses are fixed offsets from one shared pointer. A build parameter selects the memory kind:
- The first kind allows a read and a write to the same slot in one cycle, so the oldest and newest entry share a slot.
- The second kind does not. It gets one spare slot per ring and a separate read pointer.

A pulse on the start input opens a block. Sixteen valid input beats load it. The block then runs the expansion without further input, and a registered valid flag marks every output word.

Top module: `sha1_wsched`

## Requirements
- R1: While reset is high, and on the first cycle after it, `w_valid` is 0 and `w_word` is 0.
- R2: A cycle with `blk_start` high starts a new block from round 0. It discards any block in progress, whether still loading or expanding. Any `in_valid` beat in that same cycle is ignored. `w_valid` is 0 in the cycle after `blk_start`.
- R3: While a block is loading, each cycle with `in_valid` high accepts the next of the sixteen block words. That word appears on `w_word` with `w_valid` high in the following cycle, as rounds 0 to 15 in order.
- R4: During loading, a cycle with `in_valid` low produces no output word (`w_valid` 0 next cycle) and does not advance the round.
- R5: For rounds 16 to 79, `w_word` equals W[t-3] ^ W[t-8] ^ W[t-14] ^ W[t-16] rotated left by one bit. In that rotation, bit 31 of the XOR result becomes bit 0 and bit i becomes bit i+1.
- R6: Round 16 follows round 15 on the next cycle, and rounds 16 to 79 appear on 64 consecutive cycles with `w_valid` high, whatever `in_valid` does.
- R7: Exactly 80 words are output per block. After round 79, `w_valid` stays 0 until the next `blk_start`, and `in_valid` has no effect outside loading.
- R8: With `WAR_MODE` = 1 each ring has 8 slots, and the slot read as oldest is the one written that cycle. With `WAR_MODE` = 0 each ring has 9 slots and the read and write slots always differ. Both builds produce the same word sequence for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | One-cycle pulse opening a new block |
| in_valid | input | 1 | Qualifies `in_word` during loading |
| in_word | input | WORD_W | Block word, first word of the block first |
| w_valid | output | 1 | Registered flag, high for each output round |
| w_word | output | WORD_W | Registered schedule word for the current round |

## Verification
On every cycle the assertions check several things:
- the pointers stay inside the ring depth;
- a start pulse clears the round count and pointer, and silences the output next cycle;
- a loading cycle without input holds the round state;
- the round count never passes 80 and the block returns to idle after round 79;
- the read and write slots share or separate according to the memory build.

Only the bench scenarios can show the following:
- the word values themselves against an independent round-indexed schedule;
- the behaviour of stalled loading, ignored beats during expansion and in the start cycle;
- aborts in mid-load and mid-expansion;
- back-to-back blocks and the agreement of both memory builds.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  // Schedule taps, counted in rounds back from the word being produced.
  localparam int TAP_NEAR = 3;
  localparam int TAP_MID  = 8;
  localparam int TAP_FAR  = 14;
  localparam int TAP_OLD  = 16;

  // Live entries per ring; two rings cover the full sixteen-round window.
  localparam int SEG_LIVE = TAP_MID;
  localparam int OFF_NEAR = SEG_LIVE - TAP_NEAR;  // offset of W[t-3] from W[t-8]
  localparam int OFF_FAR  = TAP_OLD - TAP_FAR;    // offset of W[t-14] from W[t-16]

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_EXPAND
  } phase_e;

  function automatic logic [31:0] rotl1_32(input logic [31:0] v);
    return {v[30:0], v[31]};
  endfunction

endpackage

// File: rtl/wsched_ring.sv
module wsched_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_old,
  output logic [W-1:0]  rd_old,
  input  logic [AW-1:0] ra_near,
  output logic [W-1:0]  rd_near
);

  logic [W-1:0] mem [DEPTH];

  // Synchronous write, asynchronous read: a same-slot read returns the
  // content held before this edge's write.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_old  = mem[ra_old];
  assign rd_near = mem[ra_near];

  p_addr_range_r8: assert property (@(posedge clk)
    we |-> (int'(waddr) < DEPTH))
    else $error("ring write address out of range");

endmodule

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int N_ROUNDS  = 80,
  parameter int BLK_WORDS = 16,
  parameter int DEPTH     = 8,
  parameter bit WAR_MODE  = 1'b1,
  parameter int AW        = $clog2(DEPTH),
  parameter int CW        = $clog2(N_ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk_start,
  input  logic          in_valid,
  output logic          step,
  output logic          use_in,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] near_a,
  output logic [AW-1:0] near_b
);

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic [AW-1:0] wp;

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] p, input int unsigned k);
    logic [AW:0] s;
    s = {1'b0, p} + (AW+1)'(k);
    if (s >= (AW+1)'(DEPTH)) s = s - (AW+1)'(DEPTH);
    return s[AW-1:0];
  endfunction

  assign step   = !blk_start && ((ph == PH_LOAD && in_valid) || ph == PH_EXPAND);
  assign use_in = (ph == PH_LOAD);
  assign wr_ptr = wp;

  generate
    if (WAR_MODE) begin : g_shared_slot
      assign rd_ptr = wp;
    end else begin : g_split_slot
      assign rd_ptr = wrap_add(wp, 1);
    end
  endgenerate

  assign near_a = wrap_add(rd_ptr, OFF_NEAR);
  assign near_b = wrap_add(rd_ptr, OFF_FAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      cnt <= '0;
      wp  <= '0;
    end else if (blk_start) begin
      ph  <= PH_LOAD;
      cnt <= '0;
      wp  <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      wp  <= wrap_add(wp, 1);
      if (ph == PH_LOAD && cnt == CW'(BLK_WORDS - 1)) ph <= PH_EXPAND;
      else if (ph == PH_EXPAND && cnt == CW'(N_ROUNDS - 1)) ph <= PH_IDLE;
    end
  end

  p_ptr_range_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(wp) < DEPTH) && (int'(rd_ptr) < DEPTH))
    else $error("pointer outside ring depth");

  p_start_clear_r2: assert property (@(posedge clk) disable iff (rst)
    blk_start |=> (cnt == '0 && wp == '0 && ph == PH_LOAD))
    else $error("start did not reopen block");

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LOAD && !in_valid && !blk_start) |=> ($stable(cnt) && $stable(wp)))
    else $error("load advanced without input");

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(N_ROUNDS))
    else $error("round count beyond block length");

  p_block_end_r7: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_EXPAND && cnt == CW'(N_ROUNDS - 1) && !blk_start) |=> (ph == PH_IDLE))
    else $error("block did not end after last round");

  p_expand_run_r6: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_EXPAND && cnt != CW'(N_ROUNDS - 1) && !blk_start) |=> (ph == PH_EXPAND))
    else $error("expansion left early");

endmodule

// File: rtl/wsched_path.sv
module wsched_path
  import wsched_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int DEPTH    = 8,
  parameter bit WAR_MODE = 1'b1,
  parameter int AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              use_in,
  input  logic [WORD_W-1:0] in_word,
  input  logic [AW-1:0]     wr_ptr,
  input  logic [AW-1:0]     rd_ptr,
  input  logic [AW-1:0]     near_a,
  input  logic [AW-1:0]     near_b,
  output logic              w_valid,
  output logic [WORD_W-1:0] w_word
);

  logic [WORD_W-1:0] a_old;   // W[t-8]
  logic [WORD_W-1:0] a_near;  // W[t-3]
  logic [WORD_W-1:0] b_old;   // W[t-16]
  logic [WORD_W-1:0] b_near;  // W[t-14]
  logic [WORD_W-1:0] mix;
  logic [WORD_W-1:0] gen_w;
  logic [WORD_W-1:0] new_w;

  wsched_ring #(.W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_ring_recent (
    .clk     (clk),
    .we      (step),
    .waddr   (wr_ptr),
    .wdata   (new_w),
    .ra_old  (rd_ptr),
    .rd_old  (a_old),
    .ra_near (near_a),
    .rd_near (a_near)
  );

  // Second ring is fed by the word leaving the first.
  wsched_ring #(.W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_ring_aged (
    .clk     (clk),
    .we      (step),
    .waddr   (wr_ptr),
    .wdata   (a_old),
    .ra_old  (rd_ptr),
    .rd_old  (b_old),
    .ra_near (near_b),
    .rd_near (b_near)
  );

  assign mix   = a_near ^ a_old ^ b_near ^ b_old;
  assign gen_w = {mix[WORD_W-2:0], mix[WORD_W-1]};
  assign new_w = use_in ? in_word : gen_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_valid <= 1'b0;
      w_word  <= '0;
    end else begin
      w_valid <= step;
      if (step) w_word <= new_w;
    end
  end

  generate
    if (WAR_MODE) begin : g_chk_shared
      p_slot_shared_r8: assert property (@(posedge clk) disable iff (rst)
        step |-> (rd_ptr == wr_ptr))
        else $error("shared-slot build read a different slot");
    end else begin : g_chk_split
      p_slot_split_r8: assert property (@(posedge clk) disable iff (rst)
        step |-> (rd_ptr != wr_ptr))
        else $error("split-slot build read the written slot");
    end
  endgenerate

endmodule

// File: rtl/sha1_wsched.sv
module sha1_wsched
  import wsched_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int N_ROUNDS  = 80,
  parameter int BLK_WORDS = 16,
  parameter bit WAR_MODE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_start,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              w_valid,
  output logic [WORD_W-1:0] w_word
);

  localparam int DEPTH = WAR_MODE ? SEG_LIVE : SEG_LIVE + 1;
  localparam int AW    = $clog2(DEPTH);

  logic          step;
  logic          use_in;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] near_a;
  logic [AW-1:0] near_b;

  wsched_ctrl #(
    .N_ROUNDS  (N_ROUNDS),
    .BLK_WORDS (BLK_WORDS),
    .DEPTH     (DEPTH),
    .WAR_MODE  (WAR_MODE),
    .AW        (AW)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .blk_start (blk_start),
    .in_valid  (in_valid),
    .step      (step),
    .use_in    (use_in),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .near_a    (near_a),
    .near_b    (near_b)
  );

  wsched_path #(
    .WORD_W   (WORD_W),
    .DEPTH    (DEPTH),
    .WAR_MODE (WAR_MODE),
    .AW       (AW)
  ) u_path (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .use_in  (use_in),
    .in_word (in_word),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .near_a  (near_a),
    .near_b  (near_b),
    .w_valid (w_valid),
    .w_word  (w_word)
  );

  p_start_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    blk_start |=> !w_valid)
    else $error("output valid right after start");

endmodule

// File: tb/sha1_wsched_test.sv
`timescale 1ns/1ps
module sha1_wsched_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        blk_start = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        wv_s, wv_p;
  logic [31:0] ww_s, ww_p;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit started = 1'b0;
  localparam int WATCHDOG = 20000;

  always #2 clk = ~clk;  // 250 MHz

  sha1_wsched #(.WAR_MODE(1'b1)) uut (
    .clk(clk), .rst(rst), .blk_start(blk_start), .in_valid(in_valid),
    .in_word(in_word), .w_valid(wv_s), .w_word(ww_s)
  );

  sha1_wsched #(.WAR_MODE(1'b0)) uut_split (
    .clk(clk), .rst(rst), .blk_start(blk_start), .in_valid(in_valid),
    .in_word(in_word), .w_valid(wv_p), .w_word(ww_p)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Behavioural round-indexed reference, updated each rising edge.
  int          m_st;   // 0 idle, 1 load, 2 expand
  int          m_cnt;
  logic [31:0] m_w [80];
  bit          m_rst;
  logic        e_v;
  logic [31:0] e_w;
  string       t_v, t_w;

  always @(posedge clk) begin
    logic [31:0] x;
    started = 1'b1;
    cyc++;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_rst = 1'b1;
      e_v = 1'b0; e_w = '0; t_v = "R1"; t_w = "R1";
    end else begin
      m_rst = 1'b0;
      if (blk_start) begin
        m_st = 1; m_cnt = 0; e_v = 1'b0; t_v = "R2";
      end else if (m_st == 1) begin
        if (in_valid) begin
          m_w[m_cnt] = in_word;
          e_v = 1'b1; e_w = in_word; t_v = "R3"; t_w = "R3";
          m_cnt++;
          if (m_cnt == 16) m_st = 2;
        end else begin
          e_v = 1'b0; t_v = "R4";
        end
      end else if (m_st == 2) begin
        x = m_w[m_cnt-3] ^ m_w[m_cnt-8] ^ m_w[m_cnt-14] ^ m_w[m_cnt-16];
        m_w[m_cnt] = {x[30:0], x[31]};
        e_v = 1'b1; e_w = m_w[m_cnt]; t_v = "R6"; t_w = "R5";
        m_cnt++;
        if (m_cnt == 80) m_st = 0;
      end else begin
        e_v = 1'b0; t_v = "R7";
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(t_v, "w_valid", {31'b0, wv_s}, {31'b0, e_v});
      if (e_v || m_rst) chk(t_w, "w_word", ww_s, e_w);
      chk("R8", "split w_valid", {31'b0, wv_p}, {31'b0, e_v});
      if (e_v || m_rst) chk("R8", "split w_word", ww_p, e_w);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic start_blk(input bit with_beat);
    blk_start = 1'b1;
    in_valid  = with_beat;
    in_word   = $urandom;
    tick();
    blk_start = 1'b0;
    in_valid  = 1'b0;
  endtask

  task automatic feed(input int nwords, input bit gaps);
    for (int i = 0; i < nwords; i++) begin
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0; in_word = $urandom;
        tick();
      end
      in_valid = 1'b1; in_word = $urandom;
      tick();
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n, input bit noisy);
    for (int i = 0; i < n; i++) begin
      in_valid = noisy; in_word = $urandom;
      tick();
    end
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cyc == WATCHDOG) begin
      nchk++; nfail++;
      $display("FAIL R7 watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) tick();
    chk("R1", "reset w_valid", {31'b0, wv_s}, 32'd0);
    chk("R1", "reset w_word", ww_s, 32'd0);
    rst = 1'b0;
    tick();
    chk("R1", "post-reset w_valid", {31'b0, wv_s}, 32'd0);

    // R3 R5 R6: plain block, back-to-back words
    start_blk(1'b0); feed(16, 1'b0); idle(70, 1'b0);
    // R4 R7: stalled loading, input beats during expansion and idle ignored
    start_blk(1'b0); feed(16, 1'b1); idle(75, 1'b1);
    // R2: beat in the start cycle ignored
    start_blk(1'b1); feed(16, 1'b0); idle(70, 1'b0);
    // R2: abort in mid-expansion
    start_blk(1'b0); feed(16, 1'b0); idle(30, 1'b0);
    start_blk(1'b0); feed(16, 1'b1); idle(70, 1'b0);
    // R2: abort in mid-load
    start_blk(1'b0); feed(7, 1'b0);
    start_blk(1'b0); feed(16, 1'b0); idle(70, 1'b0);
    // R7 R8: back-to-back blocks, restart right after the last round
    for (int b = 0; b < 4; b++) begin
      start_blk(1'b0); feed(16, b[0]); idle(64, 1'b0);
    end
    idle(10, 1'b1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule